// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block holds the system control registers that a processor core reaches through its move-to-coprocessor and move-from-coprocessor operations. Each request carries two opcode fields, a primary register index, a secondary register index, a direction flag and 32 bits of write data. One cycle later the block returns a single-cycle response. The response carries read data, an error flag and a warning flag. An error means the access was not decoded or is not allowed.

The block stores the following registers: control, auxiliary control, translation table base, domain access, fault status, fault address, process identifier and coprocessor access. Two read-only constants, a main identifier and a cache type word, can also be read. The enable bits of the control register drive status outputs for the memory management unit, alignment checking, the data cache, the write buffer and the instruction cache. A write to the translation cache maintenance index does not store anything. It becomes an invalidate pulse, either for the whole cache or for one address.

Top module: `cop_sysctl_regs`

## Requirements
- R1: After reset, every writable register reads zero, every status and pulse output is low, and no response is issued until a request arrives.
- R2: Every request (`req_valid` high for one cycle) produces exactly one response with `rsp_valid` high for one cycle, on the cycle after the request. No response appears without a request. Writes return `rsp_rdata` zero, and error responses return `rsp_rdata` zero.
- R3: A request with nonzero `req_op1` sets `rsp_err` and changes no register.
- R4: For index 0, `req_op2`=0 reads the main identifier constant and `req_op2`=1 reads the cache type constant. Writes to either are accepted and have no effect. Any other `req_op2` value is an error.
- R5: For index 1, `req_op2`=0 reads and writes the full 32-bit control register and `req_op2`=1 reads and writes the auxiliary control register. Any other `req_op2` value is an error.
- R6: The control register drives the status outputs from fixed bit positions: `mmu_en` from bit 0, `align_en` from bit 1, `dcache_en` from bit 2, `wbuf_en` from bit 3 and `icache_en` from bit 12.
- R7: A control register write that would change bit 7 (byte order) is an error and leaves the control register unchanged.
- R8: Index 2 (translation table base) stores only bits 31:14, and bits 13:0 always read as zero. A write whose bits 13:0 are not all zero also sets `rsp_warn` in its response.
- R9: Index 5 (fault status) keeps only write data bits 7:0 and reads back zero-extended.
- R10: Index 3 (domain access) and index 6 (fault address) hold all 32 bits of write data, independent of `req_op2` and `req_crm`.
- R11: Indices 7 and 8 are write-only. Reading either is an error. A write to index 7 is accepted and has no visible effect.
- R12: A write to index 8 with `req_op2`=0 gives a one-cycle `inv_all` pulse with the response. With any other `req_op2`, the write gives a one-cycle `inv_addr_pulse` with `inv_addr` equal to the write data.
- R13: Index 13 is the process identifier and is legal only with `req_op2`=0 and `req_crm`=0. Index 15 with `req_crm`=1 is the 32-bit coprocessor access register. Any other index-15 access is an error. Indices 4, 9, 10, 11, 12 and 14 are errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write to the coprocessor, 0 = read from it |
| req_op1 | input | 3 | First opcode field, must be zero |
| req_op2 | input | 3 | Second opcode field, selects within an index |
| req_crn | input | 4 | Primary register index |
| req_crm | input | 4 | Secondary register index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access was illegal and had no effect |
| rsp_warn | output | 1 | Table base write had nonzero low bits |
| mmu_en | output | 1 | Control bit 0 |
| align_en | output | 1 | Control bit 1 |
| dcache_en | output | 1 | Control bit 2 |
| wbuf_en | output | 1 | Control bit 3 |
| icache_en | output | 1 | Control bit 12 |
| inv_all | output | 1 | Invalidate whole translation cache pulse |
| inv_addr_pulse | output | 1 | Invalidate one address pulse |
| inv_addr | output | 32 | Address for `inv_addr_pulse` |

## Verification
A corrupted register shows up in two ways. The next read of that index returns the wrong data one cycle after the read request. If the corruption is in the control register, the status enables change one cycle after the write that caused it. A decode mistake is visible in the same response that follows the request: the error flag is set for a legal access or clear for an illegal one, or a maintenance pulse appears on the wrong output. An illegal write that leaks into storage stays hidden until that register is read again, so the bench reads back after each rejected write.

// File: rtl/cop_sysctl_pkg.sv
package cop_sysctl_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_AUX, SEL_TTB, SEL_DAC,
    SEL_FSR, SEL_FAR, SEL_CACHEOP, SEL_TLBOP, SEL_PID, SEL_CPAR
  } csel_e;

  localparam int CTRL_MMU_BIT    = 0;
  localparam int CTRL_ALIGN_BIT  = 1;
  localparam int CTRL_DCACHE_BIT = 2;
  localparam int CTRL_WBUF_BIT   = 3;
  localparam int CTRL_BIG_BIT    = 7;
  localparam int CTRL_ICACHE_BIT = 12;

  // full-width plain storage slots
  localparam int N_PLAIN = 5;

  function automatic int plain_slot(csel_e s);
    case (s)
      SEL_AUX:  return 0;
      SEL_DAC:  return 1;
      SEL_FAR:  return 2;
      SEL_PID:  return 3;
      SEL_CPAR: return 4;
      default:  return -1;
    endcase
  endfunction

endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_sysctl_pkg::*;
(
  input  logic       is_write,
  input  logic [2:0] op1,
  input  logic [2:0] op2,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  output csel_e      sel,
  output logic       bad
);

  always_comb begin
    sel = SEL_NONE;
    bad = 1'b0;
    if (op1 != 3'd0) begin
      bad = 1'b1;
    end else begin
      case (crn)
        4'd0: begin
          if (op2 == 3'd0)      sel = SEL_ID;
          else if (op2 == 3'd1) sel = SEL_CTYPE;
          else                  bad = 1'b1;
        end
        4'd1: begin
          if (op2 == 3'd0)      sel = SEL_CTRL;
          else if (op2 == 3'd1) sel = SEL_AUX;
          else                  bad = 1'b1;
        end
        4'd2: sel = SEL_TTB;
        4'd3: sel = SEL_DAC;
        4'd5: sel = SEL_FSR;
        4'd6: sel = SEL_FAR;
        4'd7: begin
          if (is_write) sel = SEL_CACHEOP;
          else          bad = 1'b1;
        end
        4'd8: begin
          if (is_write) sel = SEL_TLBOP;
          else          bad = 1'b1;
        end
        4'd13: begin
          if (op2 == 3'd0 && crm == 4'd0) sel = SEL_PID;
          else                            bad = 1'b1;
        end
        4'd15: begin
          if (crm == 4'd1) sel = SEL_CPAR;
          else             bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cop_regbank.sv
module cop_regbank
  import cop_sysctl_pkg::*;
#(
  parameter int          DW          = 32,
  parameter int          TTB_LSB     = 14,
  parameter int          FSR_W       = 8,
  parameter logic [31:0] ID_VALUE    = 32'h4A10_2F31,
  parameter logic [31:0] CTYPE_VALUE = 32'h0B17_2192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  csel_e         sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctrl_q,
  output logic          big_change
);

  localparam int TTB_HI_W = DW - TTB_LSB;

  logic [TTB_HI_W-1:0] ttb_hi;
  logic [FSR_W-1:0]    fsr_q;
  logic [DW-1:0]       plain_q [N_PLAIN];

  assign big_change = (sel == SEL_CTRL) && (wdata[CTRL_BIG_BIT] != ctrl_q[CTRL_BIG_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ttb_hi <= '0;
      fsr_q  <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: ctrl_q <= wdata;
        SEL_TTB:  ttb_hi <= wdata[DW-1:TTB_LSB];
        SEL_FSR:  fsr_q  <= wdata[FSR_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)                                plain_q[i] <= '0;
      else if (we && plain_slot(sel) == i)    plain_q[i] <= wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:    rdata = ID_VALUE[DW-1:0];
      SEL_CTYPE: rdata = CTYPE_VALUE[DW-1:0];
      SEL_CTRL:  rdata = ctrl_q;
      SEL_TTB:   rdata = {ttb_hi, {TTB_LSB{1'b0}}};
      SEL_FSR:   rdata = {{(DW-FSR_W){1'b0}}, fsr_q};
      SEL_AUX:   rdata = plain_q[0];
      SEL_DAC:   rdata = plain_q[1];
      SEL_FAR:   rdata = plain_q[2];
      SEL_PID:   rdata = plain_q[3];
      SEL_CPAR:  rdata = plain_q[4];
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/cop_sysctl_regs.sv
module cop_sysctl_regs
  import cop_sysctl_pkg::*;
#(
  parameter int          DW          = 32,
  parameter int          TTB_LSB     = 14,
  parameter int          FSR_W       = 8,
  parameter logic [31:0] ID_VALUE    = 32'h4A10_2F31,
  parameter logic [31:0] CTYPE_VALUE = 32'h0B17_2192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_op1,
  input  logic [2:0]    req_op2,
  input  logic [3:0]    req_crn,
  input  logic [3:0]    req_crm,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          rsp_warn,
  output logic          mmu_en,
  output logic          align_en,
  output logic          dcache_en,
  output logic          wbuf_en,
  output logic          icache_en,
  output logic          inv_all,
  output logic          inv_addr_pulse,
  output logic [DW-1:0] inv_addr
);

  csel_e         sel;
  logic          bad;
  logic          big_change;
  logic          err_now;
  logic          acc_ok;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] ctrl_q;

  cop_decode u_dec (
    .is_write (req_write),
    .op1      (req_op1),
    .op2      (req_op2),
    .crn      (req_crn),
    .crm      (req_crm),
    .sel      (sel),
    .bad      (bad)
  );

  assign err_now = bad || (req_write && big_change);
  assign acc_ok  = req_valid && !err_now;

  cop_regbank #(
    .DW(DW), .TTB_LSB(TTB_LSB), .FSR_W(FSR_W),
    .ID_VALUE(ID_VALUE), .CTYPE_VALUE(CTYPE_VALUE)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .we         (acc_ok && req_write),
    .sel        (sel),
    .wdata      (req_wdata),
    .rdata      (rd_mux),
    .ctrl_q     (ctrl_q),
    .big_change (big_change)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_err        <= 1'b0;
      rsp_warn       <= 1'b0;
      inv_all        <= 1'b0;
      inv_addr_pulse <= 1'b0;
      inv_addr       <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_err        <= req_valid && err_now;
      rsp_rdata      <= (acc_ok && !req_write) ? rd_mux : '0;
      rsp_warn       <= acc_ok && req_write && (sel == SEL_TTB) &&
                        (|req_wdata[TTB_LSB-1:0]);
      inv_all        <= acc_ok && req_write && (sel == SEL_TLBOP) && (req_op2 == 3'd0);
      inv_addr_pulse <= acc_ok && req_write && (sel == SEL_TLBOP) && (req_op2 != 3'd0);
      inv_addr       <= (acc_ok && req_write && (sel == SEL_TLBOP) && (req_op2 != 3'd0))
                        ? req_wdata : '0;
    end
  end

  assign mmu_en    = ctrl_q[CTRL_MMU_BIT];
  assign align_en  = ctrl_q[CTRL_ALIGN_BIT];
  assign dcache_en = ctrl_q[CTRL_DCACHE_BIT];
  assign wbuf_en   = ctrl_q[CTRL_WBUF_BIT];
  assign icache_en = ctrl_q[CTRL_ICACHE_BIT];

  // R2: response follows request by exactly one cycle
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R3: nonzero first opcode is always flagged
  p_op1_err_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op1 != 3'd0) |=> rsp_err);
  // R7: byte-order change is rejected and enables hold
  p_big_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_op1 == 3'd0 && req_crn == 4'd1 &&
     req_op2 == 3'd0 && req_wdata[CTRL_BIG_BIT] != ctrl_q[CTRL_BIG_BIT])
    |=> rsp_err && $stable(mmu_en) && $stable(icache_en));
  // R11: reading a maintenance index is an error
  p_wo_read_err_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (req_crn == 4'd7 || req_crn == 4'd8)) |=> rsp_err);
  // R12: at most one invalidate pulse, only with a response
  p_inv_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inv_all, inv_addr_pulse}));
  p_inv_with_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    (inv_all || inv_addr_pulse) |-> (rsp_valid && !rsp_err));

endmodule

// File: tb/tb_cop_sysctl_regs.sv
module tb_cop_sysctl_regs;

  localparam logic [31:0] IDV = 32'h4A10_2F31;
  localparam logic [31:0] CTV = 32'h0B17_2192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, rsp_warn;
  logic [31:0] rsp_rdata, inv_addr;
  logic        mmu_en, align_en, dcache_en, wbuf_en, icache_en, inv_all, inv_addr_pulse;

  always #2 clk = ~clk;

  cop_sysctl_regs #(.ID_VALUE(IDV), .CTYPE_VALUE(CTV)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_op1(req_op1), .req_op2(req_op2), .req_crn(req_crn), .req_crm(req_crm),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_warn(rsp_warn), .mmu_en(mmu_en), .align_en(align_en),
    .dcache_en(dcache_en), .wbuf_en(wbuf_en), .icache_en(icache_en),
    .inv_all(inv_all), .inv_addr_pulse(inv_addr_pulse), .inv_addr(inv_addr)
  );

  typedef struct packed {
    logic [31:0] rdata;
    logic        err;
    logic        warn;
    logic        iall;
    logic        iva;
    logic [31:0] iaddr;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  task automatic acc(input bit wr, input logic [2:0] o1, input logic [2:0] o2,
                     input logic [3:0] n, input logic [3:0] m, input logic [31:0] wd,
                     input logic [31:0] erd, input bit eerr, input bit ewarn,
                     input bit eall, input bit eva, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_op1 = o1; req_op2 = o2;
    req_crn = n; req_crm = m; req_wdata = wd;
    e.rdata = erd; e.err = eerr; e.warn = ewarn; e.iall = eall; e.iva = eva;
    e.iaddr = eva ? wd : 32'h0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] n, input logic [2:0] o2, input logic [3:0] m,
                    input logic [31:0] erd, input bit eerr, input string tag);
    acc(1'b0, 3'd0, o2, n, m, 32'h0, eerr ? 32'h0 : erd, eerr, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] n, input logic [2:0] o2, input logic [3:0] m,
                    input logic [31:0] wd, input bit eerr, input string tag);
    acc(1'b1, 3'd0, o2, n, m, wd, 32'h0, eerr, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic chk_status(input logic [4:0] exp, input string tag);
    logic [4:0] act;
    act = {icache_en, wbuf_en, dcache_en, align_en, mmu_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s status actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (exp_q.size() > 0) begin
          exp_t  e;
          exp_t  a;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          a.rdata = rsp_rdata; a.err = rsp_err; a.warn = rsp_warn;
          a.iall = inv_all; a.iva = inv_addr_pulse;
          a.iaddr = inv_addr_pulse ? inv_addr : 32'h0;
          checks++;
          if (!rsp_valid || a !== e) begin
            errors++;
            $display("FAIL %s valid=%b actual rd=%h err=%b warn=%b all=%b va=%b addr=%h expected rd=%h err=%b warn=%b all=%b va=%b addr=%h",
                     t, rsp_valid, a.rdata, a.err, a.warn, a.iall, a.iva, a.iaddr,
                     e.rdata, e.err, e.warn, e.iall, e.iva, e.iaddr);
          end
        end else if (rsp_valid || inv_all || inv_addr_pulse) begin
          checks++;
          errors++;
          $display("FAIL R2 unexpected response actual valid=%b expected 0", rsp_valid);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (rsp_valid || rsp_err || inv_all || inv_addr_pulse) begin
      errors++;
      $display("FAIL R1 outputs actual=%b%b%b%b expected=0000", rsp_valid, rsp_err, inv_all, inv_addr_pulse);
    end
    chk_status(5'b00000, "R1");
    rd(4'd1, 3'd0, 4'd0, 32'h0, 1'b0, "R1 ctrl");
    rd(4'd3, 3'd0, 4'd0, 32'h0, 1'b0, "R1 dac");
    rd(4'd2, 3'd0, 4'd0, 32'h0, 1'b0, "R1 ttb");
    rd(4'd13, 3'd0, 4'd0, 32'h0, 1'b0, "R1 pid");

    // R4 identification constants
    rd(4'd0, 3'd0, 4'd0, IDV, 1'b0, "R4 id");
    rd(4'd0, 3'd1, 4'd0, CTV, 1'b0, "R4 ctype");
    wr(4'd0, 3'd0, 4'd0, 32'hFFFF_FFFF, 1'b0, "R4 id write");
    rd(4'd0, 3'd0, 4'd0, IDV, 1'b0, "R4 id after write");
    rd(4'd0, 3'd2, 4'd0, 32'h0, 1'b1, "R4 bad op2");

    // R5 / R6 control
    wr(4'd1, 3'd0, 4'd0, 32'h0000_100F, 1'b0, "R5 ctrl wr");
    chk_status(5'b11111, "R6 all on");
    rd(4'd1, 3'd0, 4'd0, 32'h0000_100F, 1'b0, "R5 ctrl rd");
    wr(4'd1, 3'd0, 4'd0, 32'h8000_0005, 1'b0, "R5 ctrl wr2");
    chk_status(5'b00101, "R6 mmu dcache");
    wr(4'd1, 3'd1, 4'd0, 32'h0000_0031, 1'b0, "R5 aux wr");
    rd(4'd1, 3'd1, 4'd0, 32'h0000_0031, 1'b0, "R5 aux rd");
    rd(4'd1, 3'd3, 4'd0, 32'h0, 1'b1, "R5 bad op2");

    // R7 byte order change rejected
    wr(4'd1, 3'd0, 4'd0, 32'h0000_1088, 1'b1, "R7 big write");
    chk_status(5'b00101, "R7 status held");
    rd(4'd1, 3'd0, 4'd0, 32'h8000_0005, 1'b0, "R7 ctrl held");

    // R8 table base
    acc(1'b1, 3'd0, 3'd0, 4'd2, 4'd0, 32'h1234_5678, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 ttb warn");
    rd(4'd2, 3'd0, 4'd0, 32'h1234_4000, 1'b0, "R8 ttb rd");
    wr(4'd2, 3'd0, 4'd0, 32'hABCD_C000, 1'b0, "R8 ttb aligned");
    rd(4'd2, 3'd0, 4'd0, 32'hABCD_C000, 1'b0, "R8 ttb rd2");

    // R9 fault status
    wr(4'd5, 3'd0, 4'd0, 32'hDEAD_BEEF, 1'b0, "R9 fsr wr");
    rd(4'd5, 3'd0, 4'd0, 32'h0000_00EF, 1'b0, "R9 fsr rd");

    // R10 domain, fault address
    wr(4'd3, 3'd4, 4'd6, 32'h5555_AAAA, 1'b0, "R10 dac wr");
    rd(4'd3, 3'd0, 4'd0, 32'h5555_AAAA, 1'b0, "R10 dac rd");
    wr(4'd6, 3'd0, 4'd0, 32'h8765_4321, 1'b0, "R10 far wr");
    rd(4'd6, 3'd2, 4'd3, 32'h8765_4321, 1'b0, "R10 far rd");

    // R3 nonzero opcode1
    acc(1'b1, 3'd1, 3'd0, 4'd3, 4'd0, 32'h0000_FFFF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 op1 write");
    rd(4'd3, 3'd0, 4'd0, 32'h5555_AAAA, 1'b0, "R3 dac held");
    acc(1'b0, 3'd2, 3'd0, 4'd0, 4'd0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 op1 read");

    // R11 write-only maintenance
    rd(4'd7, 3'd0, 4'd0, 32'h0, 1'b1, "R11 read 7");
    rd(4'd8, 3'd0, 4'd0, 32'h0, 1'b1, "R11 read 8");
    wr(4'd7, 3'd0, 4'd5, 32'h1111_1111, 1'b0, "R11 write 7");

    // R12 invalidates
    acc(1'b1, 3'd0, 3'd0, 4'd8, 4'd7, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R12 inv all");
    acc(1'b1, 3'd0, 3'd1, 4'd8, 4'd5, 32'hC0FF_EE00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R12 inv addr");

    // R13 process id, access register, undecoded
    wr(4'd13, 3'd0, 4'd0, 32'h0200_0000, 1'b0, "R13 pid wr");
    rd(4'd13, 3'd0, 4'd0, 32'h0200_0000, 1'b0, "R13 pid rd");
    wr(4'd13, 3'd1, 4'd0, 32'h0, 1'b1, "R13 pid bad op2");
    rd(4'd13, 3'd0, 4'd2, 32'h0, 1'b1, "R13 pid bad crm");
    rd(4'd13, 3'd0, 4'd0, 32'h0200_0000, 1'b0, "R13 pid held");
    wr(4'd15, 3'd0, 4'd1, 32'h0000_3FFF, 1'b0, "R13 cpar wr");
    rd(4'd15, 3'd0, 4'd1, 32'h0000_3FFF, 1'b0, "R13 cpar rd");
    rd(4'd15, 3'd0, 4'd0, 32'h0, 1'b1, "R13 idx15 bad crm");
    rd(4'd4, 3'd0, 4'd0, 32'h0, 1'b1, "R13 idx4");
    wr(4'd9, 3'd0, 4'd0, 32'h1, 1'b1, "R13 idx9");
    rd(4'd14, 3'd0, 4'd0, 32'h0, 1'b1, "R13 idx14");
    rd(4'd1, 3'd1, 4'd0, 32'h0000_0031, 1'b0, "R2 aux after errors");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule